// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block owns the program counter of a simple in-order core. In every enabled cycle it looks at the current instruction word and chooses the next PC. Most instructions step forward by one word. A compare-and-branch moves by a signed word count measured from the following instruction. An absolute jump keeps the top four bits of the current PC and fills the rest from the instruction's 26-bit target field. A register-indirect jump loads the full register value. Fetch, decoding of other instructions, delay slots and prediction belong to other blocks.

The core supplies the two comparison operands and the indirect-jump register value alongside the instruction. It also supplies an enable, so the PC can be frozen during a stall, and a synchronous active-high reset that loads a configurable start address. Two registered one-cycle flags come with the new PC. One reports that a control instruction redirected the flow. The other reports that an indirect target had non-zero low bits and was forced onto a word boundary.

Top module: `npc_unit`

## Requirements
- R1: A cycle with `rst` high loads `pc` with `START_ADDR` (default 0x0040_0000) and clears `taken` and `misalign`, whatever `en` and the instruction are.
- R2: With `en` low, `pc` keeps its value and `taken` and `misalign` read 0 after the edge, even when the instruction is a jump.
- R3: Any instruction not listed in R4, R5, R7 or R8 advances `pc` by 4 (modulo 2^32, so 0xFFFF_FFFC goes to 0) and leaves `taken` at 0. This includes opcode 0 (bits 31:26) with a function code (bits 5:0) other than 8.
- R4: Opcode 4 with `opnd_a == opnd_b` sets `pc` to PC + 4 + 4 × sign-extended bits 15:0 and raises `taken`. This applies even when the offset is 0. With unequal operands the PC advances by 4 and `taken` stays 0.
- R5: Opcode 5 branches to the same target as R4 when `opnd_a != opnd_b` and raises `taken`. With equal operands the PC advances by 4 and `taken` stays 0.
- R6: The branch offset reaches +0x1FFFC bytes (field 0x7FFF) and -0x20000 bytes (field 0x8000) relative to PC + 4.
- R7: Opcodes 2 and 3 set `pc` to {current PC bits 31:28, instruction bits 25:0, 2'b00} and raise `taken`.
- R8: Opcode 0 with function code 8 sets `pc` to `jreg_val` with bits 1:0 cleared and raises `taken`. `misalign` is 1 for that one cycle exactly when `jreg_val[1:0]` is non-zero, and 0 after every other update.
- R9: Bits 1:0 of `pc` are always 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Update enable; low holds the PC |
| instr | input | 32 | Instruction at the current PC |
| opnd_a | input | 32 | First comparison operand |
| opnd_b | input | 32 | Second comparison operand |
| jreg_val | input | 32 | Register value for indirect jumps |
| pc | output | 32 | Program counter |
| taken | output | 1 | Control redirect happened in the last enabled cycle |
| misalign | output | 1 | Last indirect target had non-zero low bits |

## Verification
The assertions assume that `instr`, the operands and `jreg_val` are steady around each rising edge. They also assume that reset is asserted at the first edge, so the PC never holds an unknown value while the checks are enabled. The bench drives every input one nanosecond after a rising edge and holds it for the whole cycle. It asserts reset from time zero for two edges, which meets both conditions. The stimulus always pairs an indirect jump with an explicit register value, and it places absolute jumps at PCs whose top bits are known, so every region-preserving check has a defined reference.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned OP_W      = 6;
    localparam int unsigned FN_W      = 6;
    localparam int unsigned OFFS_W    = 16;
    localparam int unsigned TGT_W     = 26;
    localparam int unsigned ALIGN_W   = 2;
    localparam int unsigned REGION_W  = XLEN - TGT_W - ALIGN_W;
    localparam int unsigned SEXT_W    = XLEN - OFFS_W - ALIGN_W;
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(1) << ALIGN_W;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OPC_JMP     = 6'd2;
    localparam logic [OP_W-1:0] OPC_JMPLNK  = 6'd3;
    localparam logic [OP_W-1:0] OPC_BR_EQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BR_NE   = 6'd5;
    localparam logic [FN_W-1:0] FN_JREG     = 6'd8;

    typedef enum logic [2:0] {
        CTL_SEQ,
        CTL_BEQ,
        CTL_BNE,
        CTL_JABS,
        CTL_JREG
    } ctl_kind_e;

    typedef struct packed {
        ctl_kind_e         kind;
        logic [OFFS_W-1:0] offs;
        logic [TGT_W-1:0]  tgt;
    } ctl_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] br;
        logic [XLEN-1:0] jabs;
        logic [XLEN-1:0] jreg;
        logic            jreg_mis;
    } tgt_set_t;

    function automatic ctl_kind_e classify(input logic [OP_W-1:0] op,
                                           input logic [FN_W-1:0] fn);
        ctl_kind_e k;
        case (op)
            OPC_BR_EQ:              k = CTL_BEQ;
            OPC_BR_NE:              k = CTL_BNE;
            OPC_JMP, OPC_JMPLNK:    k = CTL_JABS;
            OPC_SPECIAL:            k = (fn == FN_JREG) ? CTL_JREG : CTL_SEQ;
            default:                k = CTL_SEQ;
        endcase
        return k;
    endfunction

    function automatic logic [XLEN-1:0] word_offset(input logic [OFFS_W-1:0] f);
        return {{SEXT_W{f[OFFS_W-1]}}, f, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctl_dec_t        dec
);
    localparam int unsigned OP_LSB = XLEN - OP_W;

    always_comb begin
        dec.kind = classify(instr[XLEN-1:OP_LSB], instr[FN_W-1:0]);
        dec.offs = instr[OFFS_W-1:0];
        dec.tgt  = instr[TGT_W-1:0];
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  ctl_dec_t        dec,
    input  logic [XLEN-1:0] jreg_val,
    output tgt_set_t        tg
);
    logic [XLEN-1:0] seq_pc;

    assign seq_pc = pc + WORD_STEP;

    always_comb begin
        tg.seq      = seq_pc;
        tg.br       = seq_pc + word_offset(dec.offs);
        tg.jabs     = {pc[XLEN-1 -: REGION_W], dec.tgt, {ALIGN_W{1'b0}}};
        tg.jreg     = {jreg_val[XLEN-1:ALIGN_W], {ALIGN_W{1'b0}}};
        tg.jreg_mis = |jreg_val[ALIGN_W-1:0];
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  ctl_kind_e       kind,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  tgt_set_t        tg,
    output logic [XLEN-1:0] next_pc,
    output logic            redirect,
    output logic            mis
);
    logic same;
    assign same = (opnd_a == opnd_b);

    always_comb begin
        next_pc  = tg.seq;
        redirect = 1'b0;
        mis      = 1'b0;
        unique case (kind)
            CTL_BEQ: if (same) begin
                next_pc  = tg.br;
                redirect = 1'b1;
            end
            CTL_BNE: if (!same) begin
                next_pc  = tg.br;
                redirect = 1'b1;
            end
            CTL_JABS: begin
                next_pc  = tg.jabs;
                redirect = 1'b1;
            end
            CTL_JREG: begin
                next_pc  = tg.jreg;
                redirect = 1'b1;
                mis      = tg.jreg_mis;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] START_ADDR = 32'h0040_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [XLEN-1:0] next_pc,
    input  logic            redirect,
    input  logic            mis,
    output logic [XLEN-1:0] pc_q,
    output logic            taken_q,
    output logic            mis_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= START_ADDR;
            taken_q <= 1'b0;
            mis_q   <= 1'b0;
        end else if (en) begin
            pc_q    <= next_pc;
            taken_q <= redirect;
            mis_q   <= mis;
        end else begin
            taken_q <= 1'b0;
            mis_q   <= 1'b0;
        end
    end

    // R1
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == START_ADDR) && !taken_q && !mis_q);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc_q) && !taken_q && !mis_q);

    // R9
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        pc_q[ALIGN_W-1:0] == '0);

    // R8
    mis_needs_taken_chk: assert property (@(posedge clk) disable iff (rst)
        mis_q |-> taken_q);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] instr,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [31:0] jreg_val,
    output logic [31:0] pc,
    output logic        taken,
    output logic        misalign
);
    ctl_dec_t        dec;
    tgt_set_t        tg;
    logic [XLEN-1:0] next_pc;
    logic            redirect;
    logic            mis;

    npc_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    npc_targets u_tgt (
        .pc       (pc),
        .dec      (dec),
        .jreg_val (jreg_val),
        .tg       (tg)
    );

    npc_select u_sel (
        .kind     (dec.kind),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .tg       (tg),
        .next_pc  (next_pc),
        .redirect (redirect),
        .mis      (mis)
    );

    npc_pc_reg #(.START_ADDR(START_ADDR)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .next_pc  (next_pc),
        .redirect (redirect),
        .mis      (mis),
        .pc_q     (pc),
        .taken_q  (taken),
        .mis_q    (misalign)
    );

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        en && dec.kind == CTL_SEQ |=> !taken && (pc == $past(pc) + 32'd4));

    // R4
    beq_equal_chk: assert property (@(posedge clk) disable iff (rst)
        en && dec.kind == CTL_BEQ && opnd_a == opnd_b |=> taken);

    // R5
    bne_equal_chk: assert property (@(posedge clk) disable iff (rst)
        en && dec.kind == CTL_BNE && opnd_a == opnd_b
        |=> !taken && (pc == $past(pc) + 32'd4));

    // R7
    jabs_region_chk: assert property (@(posedge clk) disable iff (rst)
        en && dec.kind == CTL_JABS
        |=> taken && (pc[31:28] == $past(pc[31:28])));

    // R8
    jreg_load_chk: assert property (@(posedge clk) disable iff (rst)
        en && dec.kind == CTL_JREG
        |=> taken && (pc == {$past(jreg_val[31:2]), 2'b00}));
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;

    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] instr = '0, opnd_a = '0, opnd_b = '0, jreg_val = '0;
    logic [31:0] pc;
    logic        taken, misalign;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    npc_unit #(.START_ADDR(START)) u_dut (
        .clk(clk), .rst(rst), .en(en), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .jreg_val(jreg_val),
        .pc(pc), .taken(taken), .misalign(misalign)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic [31:0] exp_pc;
        logic        exp_t;
        logic        exp_m;
    } vec_t;

    // Sequence from START; each expected PC worked out by hand.
    localparam vec_t VEC [14] = '{
        '{32'h014B4820, 32'd0, 32'd0, 32'd0, 32'h0040_0004, 1'b0, 1'b0}, // R3 add
        '{32'h11090002, 32'd5, 32'd5, 32'd0, 32'h0040_0010, 1'b1, 1'b0}, // R4 beq equal
        '{32'h11090002, 32'd5, 32'd6, 32'd0, 32'h0040_0014, 1'b0, 1'b0}, // R4 beq unequal
        '{32'h15090003, 32'd1, 32'd2, 32'd0, 32'h0040_0024, 1'b1, 1'b0}, // R5 bne differ
        '{32'h15090003, 32'd7, 32'd7, 32'd0, 32'h0040_0028, 1'b0, 1'b0}, // R5 bne equal
        '{32'h1109FFFB, 32'd3, 32'd3, 32'd0, 32'h0040_0018, 1'b1, 1'b0}, // R4 backward
        '{32'h11090000, 32'd3, 32'd3, 32'd0, 32'h0040_001C, 1'b1, 1'b0}, // R4 offset 0
        '{32'h08000029, 32'd0, 32'd0, 32'd0, 32'h0000_00A4, 1'b1, 1'b0}, // R7 j
        '{32'h03E00008, 32'd0, 32'd0, 32'h9000_1000, 32'h9000_1000, 1'b1, 1'b0}, // R8
        '{32'h0BFFFFFF, 32'd0, 32'd0, 32'd0, 32'h9FFF_FFFC, 1'b1, 1'b0}, // R7 region
        '{32'h00000000, 32'd0, 32'd0, 32'd0, 32'hA000_0000, 1'b0, 1'b0}, // R3 crossing
        '{32'h0C000010, 32'd0, 32'd0, 32'd0, 32'hA000_0040, 1'b1, 1'b0}, // R7 op 3
        '{32'h03E00008, 32'd0, 32'd0, 32'h1234_5677, 32'h1234_5674, 1'b1, 1'b1}, // R8 mis
        '{32'h01CF8025, 32'd0, 32'd0, 32'h1234_5677, 32'h1234_5678, 1'b0, 1'b0}  // R3 funct 37
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive one cycle of stimulus, let one edge pass, check just after it.
    task automatic step(input logic e, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] r,
                        input string req, input logic [31:0] epc,
                        input logic et, input logic em);
        en = e; instr = ins; opnd_a = a; opnd_b = b; jreg_val = r;
        @(posedge clk); #1;
        chk(req, "pc", pc, epc);
        chk(req, "taken", {31'd0, taken}, {31'd0, et});
        chk(req, "misalign", {31'd0, misalign}, {31'd0, em});
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "pc", pc, START);
        chk("R1", "taken", {31'd0, taken}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < 14; i++)
            step(1'b1, VEC[i].ins, VEC[i].a, VEC[i].b, VEC[i].r, "R3/R4/R5/R7/R8 vec",
                 VEC[i].exp_pc, VEC[i].exp_t, VEC[i].exp_m);

        // R2 stall: a jump with en low must not move the PC
        held = pc;
        step(1'b0, 32'h03E00008, 32'd0, 32'd0, 32'h0000_0100, "R2", held, 1'b0, 1'b0);
        step(1'b0, 32'h08000001, 32'd0, 32'd0, 32'd0, "R2", held, 1'b0, 1'b0);

        // R3 wrap at the top of the address space
        step(1'b1, 32'h03E00008, 32'd0, 32'd0, 32'hFFFF_FFFC, "R8", 32'hFFFF_FFFC, 1'b1, 1'b0);
        step(1'b1, 32'h00000000, 32'd0, 32'd0, 32'd0, "R3", 32'h0000_0000, 1'b0, 1'b0);
        // R9 alignment after several redirects
        chk("R9", "pc low bits", {30'd0, pc[1:0]}, 32'd0);

        // R1 mid-run reset overrides a jump with en high
        rst = 1'b1;
        step(1'b1, 32'h08000123, 32'd0, 32'd0, 32'd0, "R1", START, 1'b0, 1'b0);
        rst = 1'b0;

        // R6 extreme offsets
        step(1'b1, 32'h11097FFF, 32'd9, 32'd9, 32'd0, "R6", 32'h0042_0000, 1'b1, 1'b0);
        step(1'b1, 32'h15098000, 32'd1, 32'd9, 32'd0, "R6", 32'h0040_0004, 1'b1, 1'b0);

        // R8 misalign flag lasts one cycle and clears on stall
        step(1'b1, 32'h03E00008, 32'd0, 32'd0, 32'h0000_2002, "R8", 32'h0000_2000, 1'b1, 1'b1);
        step(1'b0, 32'h03E00008, 32'd0, 32'd0, 32'h0000_2003, "R8", 32'h0000_2000, 1'b0, 1'b0);
        step(1'b1, 32'h03E00008, 32'd0, 32'd0, 32'h0000_3001, "R8", 32'h0000_3000, 1'b1, 1'b1);
        step(1'b1, 32'h11090001, 32'd4, 32'd4, 32'h0000_3001, "R8", 32'h0000_3008, 1'b1, 1'b0);

        summary();
        $finish;
    end
endmodule